// File: doc/BRIEF.md
# Dual-Rail Link Receiver and Encoder with Completion Detection

This block carries a word across a bus in which every data bit has two wires, a true rail and a false rail. On the receive side each pair is decoded separately. A completion tree combines the per-bit states into one hysteretic done flag. That flag rises once every bit holds a codeword and falls only after every bit has gone back to the spacer. The received word is captured when done rises and is held while done stays high. A pair with both rails high is illegal, and it raises a sticky error flag.

On the transmit side an encoder takes a single-rail word when it is ready and the caller asserts valid. It drives the codeword until its acknowledge input goes high, then returns every pair to the spacer. It is ready again only after the acknowledge has dropped, which gives a four-phase handshake with a spacer between words. Feeding the receiver's done flag back as the acknowledge closes the loop. Everything is modelled in one clock domain, and the rails are sampled as levels. An optional input register stage is chosen by a parameter.

Top module: `dr_link`

## Requirements
- R1: After reset rx_done, rx_error and rx_data are all 0, both transmit rail buses are all 0 and tx_ready is 1.
- R2: Each bit is coded as the pair {true,false}. The pair 00 is the spacer, 01 means logic 0 and 10 means logic 1. Bit i of rx_data takes the true-rail value of pair i.
- R3: rx_done rises one clock after an edge at which every pair holds 01 or 10. It stays low while any pair is at 00 or 11.
- R4: Once high, rx_done stays high until an edge at which every pair is 00, and it is low one clock after that edge.
- R5: rx_data is loaded only on the edge at which rx_done rises and stays stable while rx_done is high, even if the rails change.
- R6: Any pair at 11 at a clock edge sets rx_error from the next clock on, and rx_error stays set until reset. A pair at 11 counts neither as valid nor as spacer.
- R7: While tx_ready is high the encoder drives every pair to 00. When tx_valid and tx_ready are both high at an edge, it drives tx_word from the next clock on (true rail = word, false rail = inverted word) and holds that value until tx_ack is seen high.
- R8: After an edge with tx_ack high, the encoder drives all pairs to 00 from the next clock on. It raises tx_ready only one clock after an edge with tx_ack low.
- R9: With rx rails tied to tx rails and tx_ack tied to rx_done, the following cycle timing holds. The word appears on rx_data with rx_done high two clocks after acceptance, and tx_ready returns five clocks after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_word | input | WIDTH | Word to send |
| tx_valid | input | 1 | Word offered to encoder |
| tx_ack | input | 1 | Acknowledge from far receiver |
| tx_ready | output | 1 | Encoder idle and driving spacer |
| tx_rail_t | output | WIDTH | Transmit true rails |
| tx_rail_f | output | WIDTH | Transmit false rails |
| rx_rail_t | input | WIDTH | Receive true rails |
| rx_rail_f | input | WIDTH | Receive false rails |
| rx_data | output | WIDTH | Captured received word |
| rx_done | output | 1 | Completion flag |
| rx_error | output | 1 | Sticky illegal-pair flag |

## Verification
The assertions assume the rail inputs are steady levels across each sampling edge. They also assume that tx_ack follows the four-phase order: it rises only after a codeword was sent and falls only after the spacer. The stimulus changes rails and handshake inputs only on the falling clock edge. In loopback it closes the handshake with the receiver's own done flag, so acknowledges never arrive out of order. Pairs at 11 are driven only in the dedicated error case, and a reset follows that case.

// File: rtl/dr_pkg.sv
package dr_pkg;
   typedef enum logic [1:0] {
      ENC_IDLE = 2'd0,
      ENC_DATA = 2'd1,
      ENC_RTZ  = 2'd2
   } enc_state_e;

   localparam logic [1:0] PAIR_SPACER  = 2'b00;
   localparam logic [1:0] PAIR_ZERO    = 2'b01;
   localparam logic [1:0] PAIR_ONE     = 2'b10;
   localparam logic [1:0] PAIR_ILLEGAL = 2'b11;
endpackage

// File: rtl/dr_pair_decode.sv
module dr_pair_decode #(
   parameter int WIDTH = 8
) (
   input  logic [WIDTH-1:0] rail_t,
   input  logic [WIDTH-1:0] rail_f,
   output logic [WIDTH-1:0] bit_valid,
   output logic [WIDTH-1:0] bit_spacer,
   output logic [WIDTH-1:0] bit_illegal,
   output logic [WIDTH-1:0] bit_value
);
   import dr_pkg::*;

   for (genvar i = 0; i < WIDTH; i++) begin : g_pair
      logic [1:0] pair;
      assign pair           = {rail_t[i], rail_f[i]};
      assign bit_valid[i]   = (pair == PAIR_ZERO) || (pair == PAIR_ONE);
      assign bit_spacer[i]  = (pair == PAIR_SPACER);
      assign bit_illegal[i] = (pair == PAIR_ILLEGAL);
      assign bit_value[i]   = (pair == PAIR_ONE);
   end
endmodule

// File: rtl/dr_and_tree.sv
module dr_and_tree #(
   parameter int WIDTH = 8
) (
   input  logic [WIDTH-1:0] leaves,
   output logic             root
);
   localparam int LO_W = WIDTH / 2;
   localparam int HI_W = WIDTH - LO_W;

   if (WIDTH < 1) begin : g_bad_width
      $error("dr_and_tree: WIDTH must be at least 1");
   end

   if (WIDTH == 1) begin : g_leaf
      assign root = leaves[0];
   end else begin : g_split
      logic lo_root;
      logic hi_root;
      dr_and_tree #(.WIDTH(LO_W)) i_lo (
         .leaves(leaves[LO_W-1:0]),
         .root  (lo_root)
      );
      dr_and_tree #(.WIDTH(HI_W)) i_hi (
         .leaves(leaves[WIDTH-1:LO_W]),
         .root  (hi_root)
      );
      assign root = lo_root & hi_root;
   end
endmodule

// File: rtl/dr_completion.sv
module dr_completion (
   input  logic clk,
   input  logic rst_n,
   input  logic all_valid,
   input  logic all_spacer,
   output logic done,
   output logic done_rise
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done <= 1'b0;
      end else if (all_valid) begin
         done <= 1'b1;
      end else if (all_spacer) begin
         done <= 1'b0;
      end
   end

   assign done_rise = all_valid & ~done;

   // R4
   hold_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(done) && !$past(all_spacer)) |-> done);

   // R3
   hold_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(done) && !$past(all_valid)) |-> !done);
endmodule

// File: rtl/dr_encoder.sv
module dr_encoder #(
   parameter int WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] word,
   input  logic             valid,
   input  logic             ack,
   output logic             ready,
   output logic [WIDTH-1:0] rail_t,
   output logic [WIDTH-1:0] rail_f
);
   import dr_pkg::*;

   enc_state_e       state;
   logic [WIDTH-1:0] word_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= ENC_IDLE;
         word_q <= '0;
      end else begin
         unique case (state)
            ENC_IDLE: if (valid) begin
               state  <= ENC_DATA;
               word_q <= word;
            end
            ENC_DATA: if (ack)  state <= ENC_RTZ;
            ENC_RTZ:  if (!ack) state <= ENC_IDLE;
            default:            state <= ENC_IDLE;
         endcase
      end
   end

   assign ready  = (state == ENC_IDLE);
   assign rail_t = (state == ENC_DATA) ? word_q  : '0;
   assign rail_f = (state == ENC_DATA) ? ~word_q : '0;

   // R7
   idle_spacer_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ready |-> (rail_t == '0 && rail_f == '0));

   // R7
   data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((|$past(rail_t | rail_f)) && !$past(ack)) |->
         ($stable(rail_t) && $stable(rail_f)));

   // R8
   ready_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ready) |-> !$past(ack));
endmodule

// File: rtl/dr_link.sv
module dr_link #(
   parameter int WIDTH  = 8,
   parameter bit REG_IN = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] tx_word,
   input  logic             tx_valid,
   input  logic             tx_ack,
   output logic             tx_ready,
   output logic [WIDTH-1:0] tx_rail_t,
   output logic [WIDTH-1:0] tx_rail_f,
   input  logic [WIDTH-1:0] rx_rail_t,
   input  logic [WIDTH-1:0] rx_rail_f,
   output logic [WIDTH-1:0] rx_data,
   output logic             rx_done,
   output logic             rx_error
);
   if (WIDTH < 1) begin : g_bad_width
      $error("dr_link: WIDTH must be at least 1");
   end

   logic [WIDTH-1:0] s_t, s_f;

   if (REG_IN) begin : g_reg_in
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            s_t <= '0;
            s_f <= '0;
         end else begin
            s_t <= rx_rail_t;
            s_f <= rx_rail_f;
         end
      end
   end else begin : g_direct_in
      assign s_t = rx_rail_t;
      assign s_f = rx_rail_f;
   end

   logic [WIDTH-1:0] bit_valid, bit_spacer, bit_illegal, bit_value;
   logic             all_valid, all_spacer, done_rise;

   dr_pair_decode #(.WIDTH(WIDTH)) i_decode (
      .rail_t     (s_t),
      .rail_f     (s_f),
      .bit_valid  (bit_valid),
      .bit_spacer (bit_spacer),
      .bit_illegal(bit_illegal),
      .bit_value  (bit_value)
   );

   dr_and_tree #(.WIDTH(WIDTH)) i_valid_tree (
      .leaves(bit_valid),
      .root  (all_valid)
   );

   dr_and_tree #(.WIDTH(WIDTH)) i_spacer_tree (
      .leaves(bit_spacer),
      .root  (all_spacer)
   );

   dr_completion i_completion (
      .clk       (clk),
      .rst_n     (rst_n),
      .all_valid (all_valid),
      .all_spacer(all_spacer),
      .done      (rx_done),
      .done_rise (done_rise)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_data  <= '0;
         rx_error <= 1'b0;
      end else begin
         if (done_rise) rx_data <= bit_value;
         if (|bit_illegal) rx_error <= 1'b1;
      end
   end

   dr_encoder #(.WIDTH(WIDTH)) i_encoder (
      .clk   (clk),
      .rst_n (rst_n),
      .word  (tx_word),
      .valid (tx_valid),
      .ack   (tx_ack),
      .ready (tx_ready),
      .rail_t(tx_rail_t),
      .rail_f(tx_rail_f)
   );

   // R3
   done_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rx_done) |-> ($past((s_t ^ s_f) == '1)));

   // R4
   done_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(rx_done) |-> ($past((s_t | s_f) == '0)));

   // R5
   data_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_done && $past(rx_done)) |-> $stable(rx_data));

   // R6
   error_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rx_error) |-> rx_error);
endmodule

// File: tb/test_dr_link.sv
module test_dr_link;
   localparam int W = 4;
   localparam int N = 1 << W;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [W-1:0] tx_word = '0;
   logic         tx_valid = 1'b0;
   logic         loop = 1'b1;
   logic [W-1:0] man_t = '0, man_f = '0;
   logic         tx_ready, rx_done, rx_error;
   logic [W-1:0] tx_rail_t, tx_rail_f, rx_data;
   logic [W-1:0] rx_t, rx_f;
   logic         ack;

   int checks = 0;
   int fails  = 0;
   int cycles = 0;

   assign rx_t = loop ? tx_rail_t : man_t;
   assign rx_f = loop ? tx_rail_f : man_f;
   assign ack  = loop ? rx_done : 1'b0;

   always #2 clk = ~clk;

   dr_link #(.WIDTH(W)) i_dr_link (
      .clk(clk), .rst_n(rst_n),
      .tx_word(tx_word), .tx_valid(tx_valid), .tx_ack(ack),
      .tx_ready(tx_ready), .tx_rail_t(tx_rail_t), .tx_rail_f(tx_rail_f),
      .rx_rail_t(rx_t), .rx_rail_f(rx_f),
      .rx_data(rx_data), .rx_done(rx_done), .rx_error(rx_error)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   endtask

   task automatic set_pair(input int i, input logic [1:0] p);
      man_t[i] = p[1];
      man_f[i] = p[0];
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 100000) begin
         chk(1'b0, "watchdog", cycles, 100000);
         finish_run();
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(rx_done == 0 && rx_error == 0 && rx_data == 0, "R1 rx", {rx_done, rx_error, rx_data}, 0);
      chk(tx_rail_t == 0 && tx_rail_f == 0 && tx_ready == 1, "R1 tx", {tx_ready, tx_rail_t, tx_rail_f}, 256);

      // Loopback sweep over every word: R2 R7 R8 R9
      for (int w = 0; w < N; w++) begin
         tx_word = W'(w);
         tx_valid = 1'b1;
         @(negedge clk);
         tx_valid = 1'b0;
         chk(tx_rail_t == W'(w) && tx_rail_f == ~W'(w), "R7 codeword", {tx_rail_t, tx_rail_f}, {w[W-1:0], ~w[W-1:0]});
         chk(tx_ready == 0, "R7 busy", tx_ready, 0);
         @(negedge clk);
         chk(rx_done == 1 && rx_data == W'(w), "R9 data", {rx_done, rx_data}, 16 + w);
         chk(rx_data == W'(w), "R2 decode", rx_data, w);
         @(negedge clk);
         chk(tx_rail_t == 0 && tx_rail_f == 0, "R8 spacer", {tx_rail_t, tx_rail_f}, 0);
         chk(rx_done == 1, "R4 held", rx_done, 1);
         @(negedge clk);
         chk(rx_done == 0, "R4 fall", rx_done, 0);
         chk(tx_ready == 0, "R8 wait ack low", tx_ready, 0);
         @(negedge clk);
         chk(tx_ready == 1, "R9 ready", tx_ready, 1);
      end

      // Manual drive: staggered arrival, R3 R4 R5
      loop = 1'b0;
      @(negedge clk);
      for (int w = 0; w < N; w++) begin
         for (int k = 0; k < W; k++) begin
            int b;
            b = (w % 2 == 0) ? k : (W - 1 - k);
            set_pair(b, w[b] ? 2'b10 : 2'b01);
            @(negedge clk);
            if (k < W - 1) chk(rx_done == 0, "R3 partial", rx_done, 0);
            else chk(rx_done == 1 && rx_data == W'(w), "R3 complete", {rx_done, rx_data}, 16 + w);
         end
         set_pair(0, 2'b00);
         @(negedge clk);
         chk(rx_done == 1 && rx_data == W'(w), "R4 partial spacer", {rx_done, rx_data}, 16 + w);
         set_pair(0, w[0] ? 2'b01 : 2'b10);
         @(negedge clk);
         chk(rx_done == 1 && rx_data == W'(w), "R5 data held", {rx_done, rx_data}, 16 + w);
         man_t = '0;
         man_f = '0;
         @(negedge clk);
         chk(rx_done == 0, "R4 all spacer", rx_done, 0);
         chk(rx_error == 0, "R6 no error", rx_error, 0);
      end

      // Illegal pair: R6
      set_pair(0, 2'b01);
      set_pair(1, 2'b10);
      set_pair(2, 2'b01);
      set_pair(3, 2'b11);
      @(negedge clk);
      chk(rx_error == 1, "R6 set", rx_error, 1);
      chk(rx_done == 0, "R6 not valid", rx_done, 0);
      man_t = '0;
      man_f = '0;
      @(negedge clk);
      chk(rx_error == 1, "R6 sticky", rx_error, 1);
      set_pair(3, 2'b11);
      set_pair(0, 2'b11);
      @(negedge clk);
      man_t = '0;
      man_f = '0;
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(rx_error == 0 && rx_done == 0, "R1 R6 cleared", {rx_error, rx_done}, 0);

      finish_run();
   end
endmodule